// File: doc/BRIEF.md
# SCSI Target Move Sequencer with Command-Length Override

This block runs one byte-move instruction for a device acting as a SCSI target. An instruction arrives on a valid/ready port. It carries a three-bit bus phase, a byte count, a start address and two policy bits: a vendor-unique enable and a halt-deferral flag. The block first checks that the device is operating as a target. It then holds the phase on three bus phase outputs and moves bytes over a valid/ready byte stream. Each accepted byte decrements the remaining count and advances the current address.

In command phase, the first byte received is decoded before the count is used. Its top three bits form a group code. For groups with a known descriptor length, that length replaces the programmed count, and the first byte counts as one of those bytes. Attention or a parity error from the bus can end the move. Depending on the deferral flag, the move ends on the spot or finishes its count first and then reports the halt.

Back-pressure rules:
- The instruction port accepts only while the block is idle.
- The byte stream accepts only while a move is active and no immediate halt is pending.
- A byte is consumed only on a cycle where valid and ready are both high.
- The sender may hold valid high across any number of stalled cycles.

Top module: `scsi_tgt_move_seq`

## Requirements
- R1: An instruction accepted while `is_target` is low raises `irq_illegal` for one cycle on the next clock, drives no phase and accepts no bytes.
- R2: While a move is active, {`phase_msg`,`phase_cd`,`phase_io`} equal instruction phase bits [2],[1],[0] and stay stable. While idle, all three are 0.
- R3: In command phase (phase 3'b010), a first byte with bits [7:5] equal to 0, 1, 2 or 5 sets the total transfer to 6, 10, 10 or 12 bytes respectively, and the first byte is included in that total.
- R4: With the vendor-unique enable clear, group codes 6 and 7 set the total to 6 and 10 bytes.
- R5: With the vendor-unique enable set, groups 6 and 7 use the programmed count. Groups 3 and 4 always use the programmed count.
- R6: When the count to be used is 0, `irq_illegal` pulses and no further bytes are taken. In a non-command phase this happens at instruction acceptance with no bytes taken. In command phase it happens on the first byte, with only that byte taken.
- R7: The n-th byte of a move (counting from 0) is taken while `cur_addr` equals start address + n, modulo 2^ADDR_W. `cur_count` drops by one per byte taken.
- R8: `done` pulses for exactly one cycle on the clock that takes the last byte. After that the block is idle and `ins_ready` is high.
- R9: With halt deferral clear, `atn` or `par_err` high during a move forces `rx_ready` low in that cycle. `irq_halt` then pulses on the next clock, the block returns to idle, and `done` does not pulse.
- R10: With halt deferral set, `atn` or `par_err` during a move does not stop it. When the count completes, `done` and `irq_halt` pulse in the same cycle.
- R11: `ins_ready` is high exactly when idle. `rx_ready` is never high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_target | input | 1 | Device currently connected as a target |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Instruction accepted (idle) |
| ins_phase | input | 3 | Phase field: [2] message, [1] control/data, [0] input/output |
| ins_count | input | CNT_W | Programmed byte count |
| ins_addr | input | ADDR_W | Start address |
| ins_vue_en | input | 1 | Vendor-unique enable: keep programmed count for groups 6 and 7 |
| ins_halt_defer | input | 1 | 1: halt only after the move completes; 0: halt at once |
| rx_valid | input | 1 | Byte offered on the stream |
| rx_ready | output | 1 | Byte taken when valid is also high |
| rx_data | input | 8 | Byte value; bits [7:5] decoded for the first command byte |
| atn | input | 1 | Attention from the initiator |
| par_err | input | 1 | Parity error on the current byte |
| phase_msg | output | 1 | Message phase line |
| phase_cd | output | 1 | Control/data phase line |
| phase_io | output | 1 | Input/output phase line |
| cur_count | output | CNT_W | Bytes still to be moved |
| cur_addr | output | ADDR_W | Address of the next byte |
| done | output | 1 | Move completed (one-cycle pulse) |
| irq_illegal | output | 1 | Illegal instruction (one-cycle pulse) |
| irq_halt | output | 1 | Halt on attention or parity (one-cycle pulse) |

## Verification
The bench keeps CNT_W at 24 and narrows ADDR_W to 8. This lets moves started near the top of the address space wrap, so address carry and modulo behaviour are exercised within a few bytes. A 24-bit count covers both the zero-count illegal path and small programmed counts. Group decoding can therefore be compared against programmed counts that are smaller or larger than the fixed descriptor lengths.

// File: rtl/tgtmv_pkg.sv
package tgtmv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_MOVE  = 2'd2
  } tgtmv_state_e;

  localparam logic [2:0] PH_CMD = 3'b010;
endpackage

// File: rtl/tgtmv_grp_decode.sv
module tgtmv_grp_decode #(
  parameter int CNT_W = 24
) (
  input  logic [2:0]       grp,
  input  logic             vue_en,
  output logic             use_fixed,
  output logic [CNT_W-1:0] fixed_len
);
  always_comb begin
    use_fixed = 1'b0;
    fixed_len = '0;
    case (grp)
      3'd0: begin use_fixed = 1'b1;    fixed_len = CNT_W'(6);  end
      3'd1,
      3'd2: begin use_fixed = 1'b1;    fixed_len = CNT_W'(10); end
      3'd5: begin use_fixed = 1'b1;    fixed_len = CNT_W'(12); end
      3'd6: begin use_fixed = !vue_en; fixed_len = CNT_W'(6);  end
      3'd7: begin use_fixed = !vue_en; fixed_len = CNT_W'(10); end
      default: begin use_fixed = 1'b0; fixed_len = '0; end
    endcase
  end
endmodule

// File: rtl/tgtmv_xfer_ctr.sv
module tgtmv_xfer_ctr #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [CNT_W-1:0]  ld_cnt,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              step_en,
  input  logic              ovr_en,
  input  logic [CNT_W-1:0]  ovr_cnt,
  output logic [CNT_W-1:0]  cnt,
  output logic [ADDR_W-1:0] addr
);
  logic [CNT_W-1:0] base_cnt;

  assign base_cnt = ovr_en ? ovr_cnt : cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      addr <= '0;
    end else if (ld_en) begin
      cnt  <= ld_cnt;
      addr <= ld_addr;
    end else if (step_en) begin
      cnt  <= base_cnt - 1'b1;
      addr <= addr + 1'b1;
    end
  end
endmodule

// File: rtl/scsi_tgt_move_seq.sv
module scsi_tgt_move_seq
  import tgtmv_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_target,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [2:0]        ins_phase,
  input  logic [CNT_W-1:0]  ins_count,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              ins_vue_en,
  input  logic              ins_halt_defer,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              atn,
  input  logic              par_err,
  output logic              phase_msg,
  output logic              phase_cd,
  output logic              phase_io,
  output logic [CNT_W-1:0]  cur_count,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              done,
  output logic              irq_illegal,
  output logic              irq_halt
);
  tgtmv_state_e state_q, state_d;
  logic [2:0] phase_q;
  logic vue_q, defer_q, pend_q, pend_d;
  logic done_d, ill_d, halt_d;
  logic busy, halt_req, halt_now, rx_hs, first_hs, first_zero;
  logic ins_fire, start_ok, step_en, ovr_en, last_byte;
  logic use_fixed;
  logic [CNT_W-1:0] fixed_len;

  assign busy      = (state_q != ST_IDLE);
  assign halt_req  = atn | par_err;
  assign halt_now  = busy & halt_req & ~defer_q;
  assign ins_ready = (state_q == ST_IDLE);
  assign rx_ready  = busy & ~halt_now;
  assign rx_hs     = rx_valid & rx_ready;
  assign first_hs  = rx_hs & (state_q == ST_FIRST);
  assign ins_fire  = ins_valid & ins_ready;
  assign start_ok  = ins_fire & is_target &
                     ((ins_phase == PH_CMD) || (ins_count != '0));

  tgtmv_grp_decode #(.CNT_W(CNT_W)) u_grp (
    .grp       (rx_data[7:5]),
    .vue_en    (vue_q),
    .use_fixed (use_fixed),
    .fixed_len (fixed_len)
  );

  assign ovr_en     = first_hs & use_fixed;
  assign first_zero = first_hs & ~use_fixed & (cur_count == '0);
  assign step_en    = rx_hs & ~first_zero;
  assign last_byte  = step_en & ~ovr_en & (cur_count == CNT_W'(1));

  tgtmv_xfer_ctr #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (start_ok),
    .ld_cnt  (ins_count),
    .ld_addr (ins_addr),
    .step_en (step_en),
    .ovr_en  (ovr_en),
    .ovr_cnt (fixed_len),
    .cnt     (cur_count),
    .addr    (cur_addr)
  );

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    done_d  = 1'b0;
    ill_d   = 1'b0;
    halt_d  = 1'b0;
    if (state_q == ST_IDLE) begin
      if (ins_fire) begin
        if (start_ok) begin
          state_d = (ins_phase == PH_CMD) ? ST_FIRST : ST_MOVE;
          pend_d  = 1'b0;
        end else begin
          ill_d = 1'b1;
        end
      end
    end else if (halt_now) begin
      halt_d  = 1'b1;
      state_d = ST_IDLE;
    end else begin
      if (halt_req) pend_d = 1'b1;
      if (first_zero) begin
        ill_d   = 1'b1;
        pend_d  = 1'b0;
        state_d = ST_IDLE;
      end else if (last_byte) begin
        done_d  = 1'b1;
        halt_d  = pend_d;
        state_d = ST_IDLE;
      end else if (first_hs) begin
        state_d = ST_MOVE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      phase_q     <= '0;
      vue_q       <= 1'b0;
      defer_q     <= 1'b0;
      pend_q      <= 1'b0;
      done        <= 1'b0;
      irq_illegal <= 1'b0;
      irq_halt    <= 1'b0;
    end else begin
      state_q     <= state_d;
      pend_q      <= pend_d;
      done        <= done_d;
      irq_illegal <= ill_d;
      irq_halt    <= halt_d;
      if (state_d == ST_IDLE) phase_q <= '0;
      else if (start_ok)      phase_q <= ins_phase;
      if (start_ok) begin
        vue_q   <= ins_vue_en;
        defer_q <= ins_halt_defer;
      end
    end
  end

  assign phase_msg = phase_q[2];
  assign phase_cd  = phase_q[1];
  assign phase_io  = phase_q[0];

  p_no_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_fire && !is_target) |=> (irq_illegal && ins_ready));
  p_idle_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ready |-> ({phase_msg, phase_cd, phase_io} == 3'b000));
  p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable({phase_msg, phase_cd, phase_io})));
  p_grp5_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (first_hs && rx_data[7:5] == 3'd5) |=> (cur_count == CNT_W'(11)));
  p_illegal_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && irq_illegal));
  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MOVE && rx_hs) |=> (cur_count == $past(cur_count) - 1'b1));
  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hs && !first_zero) |=> (cur_addr == $past(cur_addr) + 1'b1));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_halt_now_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halt_now |=> (irq_halt && !done && ins_ready));
  p_idle_no_rx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ready |-> !rx_ready);
endmodule

// File: tb/sim_scsi_tgt_move_seq.sv
module sim_scsi_tgt_move_seq;
  localparam int CLK_P  = 10;
  localparam int CNT_W  = 24;
  localparam int ADDR_W = 8;
  localparam logic [2:0] CMD = 3'b010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic is_target = 1'b1;
  logic ins_valid = 1'b0;
  logic ins_ready;
  logic [2:0] ins_phase = '0;
  logic [CNT_W-1:0] ins_count = '0;
  logic [ADDR_W-1:0] ins_addr = '0;
  logic ins_vue_en = 1'b0;
  logic ins_halt_defer = 1'b0;
  logic rx_valid = 1'b0;
  logic rx_ready;
  logic [7:0] rx_data = '0;
  logic atn = 1'b0;
  logic par_err = 1'b0;
  logic phase_msg, phase_cd, phase_io;
  logic [CNT_W-1:0] cur_count;
  logic [ADDR_W-1:0] cur_addr;
  logic done, irq_illegal, irq_halt;
  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  scsi_tgt_move_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .is_target(is_target),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_phase(ins_phase),
    .ins_count(ins_count), .ins_addr(ins_addr), .ins_vue_en(ins_vue_en),
    .ins_halt_defer(ins_halt_defer), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .atn(atn), .par_err(par_err), .phase_msg(phase_msg),
    .phase_cd(phase_cd), .phase_io(phase_io), .cur_count(cur_count),
    .cur_addr(cur_addr), .done(done), .irq_illegal(irq_illegal),
    .irq_halt(irq_halt)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_total(input logic [2:0] ph, input int cnt, input bit vue, input logic [7:0] fb);
    if (ph != CMD) return cnt;
    case (fb[7:5])
      3'd0: return 6;
      3'd1, 3'd2: return 10;
      3'd5: return 12;
      3'd6: return vue ? cnt : 6;
      3'd7: return vue ? cnt : 10;
      default: return cnt;
    endcase
  endfunction

  task automatic run_move(input bit tgt, input logic [2:0] ph, input int cnt,
                          input logic [7:0] addr, input bit vue, input bit defer,
                          input logic [7:0] fb, input int halt_in, input bit use_par);
    int total, exp_bytes, idx, halt_at;
    bit exp_ill, exp_halt, exp_done, got_done, got_ill, got_halt, hs, first, fin, sig;
    total = exp_total(ph, cnt, vue, fb);
    halt_at = halt_in;
    exp_ill = 0; exp_halt = 0; exp_done = 0; exp_bytes = 0;
    if (!tgt) begin exp_ill = 1; halt_at = -1; end
    else if (total == 0) begin exp_ill = 1; halt_at = -1; exp_bytes = (ph == CMD) ? 1 : 0; end
    else if (halt_at >= 0 && halt_at < total) begin
      exp_halt = 1;
      if (defer) begin exp_done = 1; exp_bytes = total; end
      else exp_bytes = halt_at;
    end else begin exp_done = 1; exp_bytes = total; end

    @(negedge clk);
    is_target = tgt; ins_phase = ph; ins_count = CNT_W'(cnt); ins_addr = addr;
    ins_vue_en = vue; ins_halt_defer = defer; ins_valid = 1'b1;
    #1 chk(ins_ready == 1'b1, "R11 ins_ready when idle", ins_ready, 1);
    @(posedge clk);
    @(negedge clk);
    ins_valid = 1'b0;
    idx = 0; first = 1; fin = 0; got_done = 0; got_ill = 0; got_halt = 0;
    for (int cyc = 0; cyc < 600 && !fin; cyc++) begin
      if (done || irq_illegal || irq_halt) begin
        got_done = done; got_ill = irq_illegal; got_halt = irq_halt; fin = 1;
      end else begin
        if (first)
          chk({phase_msg, phase_cd, phase_io} == ph, "R2 phase lines",
              {phase_msg, phase_cd, phase_io}, ph);
        first = 0;
        sig = (halt_at >= 0) && (idx >= halt_at);
        atn = sig & !use_par;
        par_err = sig & use_par;
        rx_valid = ($urandom_range(0, 3) != 0);
        rx_data = (idx == 0) ? fb : 8'($urandom);
        #1 hs = rx_valid && rx_ready;
        if (hs)
          chk(cur_addr == 8'(addr + idx), "R7 address per byte", cur_addr, 8'(addr + idx));
        @(posedge clk);
        @(negedge clk);
        if (hs) idx++;
      end
    end
    rx_valid = 1'b0; atn = 1'b0; par_err = 1'b0;
    chk(idx == exp_bytes, "R3/R4/R5 bytes moved", idx, exp_bytes);
    chk(got_done == exp_done, "R8/R10 done pulse", got_done, exp_done);
    chk(got_ill == exp_ill, "R1/R6 illegal irq", got_ill, exp_ill);
    chk(got_halt == exp_halt, "R9/R10 halt irq", got_halt, exp_halt);
    chk({phase_msg, phase_cd, phase_io} == 3'b000, "R2 idle phase", {phase_msg, phase_cd, phase_io}, 0);
    rx_valid = 1'b1;
    #1 chk(rx_ready == 1'b0, "R11 no rx_ready when idle", rx_ready, 0);
    rx_valid = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R8 single-cycle done", done, 0);
    chk(ins_ready == 1'b1, "R8 ready after move", ins_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk(ins_ready == 1'b0 || ins_ready == 1'b1, "R11 reset ready known", ins_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && irq_illegal == 0 && irq_halt == 0, "R8 reset pulses low", done, 0);
    chk(ins_ready == 1 && rx_ready == 0, "R11 reset idle", ins_ready, 1);
    // R3: fixed groups
    run_move(1, CMD, 3,  8'h10, 0, 0, 8'h00, -1, 0);
    run_move(1, CMD, 3,  8'h20, 1, 0, 8'h28, -1, 0);
    run_move(1, CMD, 30, 8'h30, 0, 0, 8'h5F, -1, 0);
    run_move(1, CMD, 2,  8'h40, 1, 0, 8'hA1, -1, 0);
    // R4: vendor-unique groups with enable clear
    run_move(1, CMD, 2,  8'h50, 0, 0, 8'hC0, -1, 0);
    run_move(1, CMD, 2,  8'h60, 0, 0, 8'hE3, -1, 0);
    // R5: programmed count kept
    run_move(1, CMD, 3,  8'h70, 1, 0, 8'hC5, -1, 0);
    run_move(1, CMD, 15, 8'h70, 1, 0, 8'hFF, -1, 0);
    run_move(1, CMD, 4,  8'h80, 0, 0, 8'h60, -1, 0);
    run_move(1, CMD, 1,  8'h80, 0, 0, 8'h9A, -1, 0);
    // R6: zero count
    run_move(1, CMD, 0,  8'h90, 0, 0, 8'h80, -1, 0);
    run_move(1, 3'b001, 0, 8'h90, 0, 0, 8'h00, -1, 0);
    // R1: not a target
    run_move(0, 3'b000, 5, 8'h90, 0, 0, 8'h00, -1, 0);
    // R7: address wrap
    run_move(1, 3'b000, 10, 8'hFC, 0, 0, 8'h00, -1, 0);
    // R9: immediate halt
    run_move(1, 3'b001, 8, 8'hA0, 0, 0, 8'h00, 3, 0);
    run_move(1, CMD,    8, 8'hB0, 0, 0, 8'h20, 0, 1);
    // R10: deferred halt
    run_move(1, 3'b111, 6, 8'hC0, 0, 1, 8'h00, 2, 0);
    run_move(1, CMD,    4, 8'hD0, 0, 1, 8'h00, 5, 1);
    for (int n = 0; n < 60; n++) begin
      int c, h, t;
      logic [2:0] ph;
      logic [7:0] fb;
      bit vue;
      ph  = 3'($urandom);
      if ($urandom_range(0, 2) == 0) ph = CMD;
      c   = ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(1, 16);
      fb  = 8'($urandom);
      vue = 1'($urandom);
      t   = exp_total(ph, c, vue, fb);
      h   = ($urandom_range(0, 2) == 0) ? $urandom_range(0, t + 2) : -1;
      run_move($urandom_range(0, 9) != 0, ph, c, 8'($urandom), vue,
               1'($urandom), fb, h, 1'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule